// File: doc/BRIEF.md
# Buck Start-Up Sequencer with Power-Good Window

This block supervises the start-up of a voltage-mode buck converter. It watches a supply-lockout flag, an enable input, a thermal-fault flag and two digitized analog levels: the soft-start ramp and the output feedback sample. From these it decides what the soft-start ramp pin does (charge, discharge or hold high). It also decides when the PWM may switch, when the low-side switch may take part, and what reference the error amplifier sees. A power-good indication is pulled low whenever the output is outside its window or start-up is incomplete.

Start-up runs in two stages. Once the ramp passes the switching threshold, the PWM runs with the high-side switch only (asynchronous mode). The error-amplifier reference follows the ramp, shifted down by the switching threshold, and is capped at its final value. At a second, higher ramp threshold, synchronous rectification is enabled, the reference is released, the ramp is held high and the power-good mask is lifted. The ramp thresholds are given in millivolts and converted to codes against a supply full scale. The feedback window is given in millivolts against its own full scale.

Top module: `softstart_pg_seq`

## Requirements
- R1: While `uvlo_i` is high at a clock edge, the block is in shutdown after that edge: `switch_en_o`=0, `async_mode_o`=1, `ramp_discharge_o`=1, `pgood_pull_o`=1, `ref_code_o`=0. Reset gives the same state.
- R2: `en_i` low at a clock edge forces shutdown after that edge. A ramp code below the disable code (85 by default) forces shutdown only while the PWM is switching. In the charging stage it has no effect.
- R3: From shutdown with the block enabled, the next edge enters the charging stage. There the ramp charges and `switch_en_o`=0. The first edge with the ramp at or above the switching code (170) starts switching with `async_mode_o`=1. The block advances by at most one stage per edge.
- R4: While the reference is not released, `ref_code_o` = min(max(ramp−170, 0), 85) in the charging and switching stages, and 0 in shutdown.
- R5: In the switching stage, the first edge with the ramp at or above the completion code (341) enters run. In run: `async_mode_o`=0, `ref_release_o`=1, `ramp_hold_hi_o`=1, `ramp_charge_o`=0, `ref_code_o`=85.
- R6: `pgood_pull_o` is 1 in every stage except run, whatever the feedback code.
- R7: In run, `pgood_pull_o` goes to 1 one edge after feedback rises above 562 or falls below 460.
- R8: The over-limit flag clears only when feedback drops below 556. The under-limit flag clears only when feedback rises above 466. Codes between a trip point and its release point hold the flag.
- R9: `therm_i` high forces `switch_en_o`=0 and `async_mode_o`=1 in the same cycle, with no clock edge needed. The next edge enters shutdown.
- R10: At most one of `ramp_charge_o`, `ramp_discharge_o`, `ramp_hold_hi_o` is high at a time. Shutdown discharges, the charging and switching stages charge, and run holds high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Supply below lockout threshold |
| en_i | input | 1 | Enable; low requests shutdown |
| therm_i | input | 1 | Thermal fault |
| ramp_code_i | input | CODE_W | Digitized soft-start ramp level |
| fb_code_i | input | CODE_W | Digitized feedback level |
| ramp_charge_o | output | 1 | Turn on ramp charge current |
| ramp_discharge_o | output | 1 | Turn on ramp discharge sink |
| ramp_hold_hi_o | output | 1 | Pull ramp fully high |
| async_mode_o | output | 1 | Low-side switch held off |
| switch_en_o | output | 1 | PWM switching allowed |
| ref_release_o | output | 1 | Reference at final value |
| ref_code_o | output | CODE_W | Error-amplifier reference code |
| pgood_pull_o | output | 1 | 1 pulls power-good low |

## Verification
A wrong stage register shows at the ramp-control and drive outputs one edge after the input that caused it. For example, a skipped charging stage raises `switch_en_o` before the ramp reaches 170, and a missed exit from switching keeps `async_mode_o` high past 341. A wrong window flag shows on `pgood_pull_o` one edge after feedback crosses a trip or release code, so vectors sit on both sides of each edge. A tracking error shows at once on `ref_code_o`, because that output follows the ramp input without a register.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_CHARGE = 2'd1,
      ST_SOFT   = 2'd2,
      ST_RUN    = 2'd3
   } ssp_state_e;

   // Convert a millivolt level to an unsigned code against a full scale.
   function automatic int mv2code(input int mv, input int fs_mv, input int width);
      longint num;
      num = longint'(mv) * ((longint'(1) << width) - 1);
      return int'(num / fs_mv);
   endfunction

endpackage

// File: rtl/ssp_ramp_cmp.sv
module ssp_ramp_cmp #(
   parameter int CODE_W  = 10,
   parameter int DIS_C   = 85,
   parameter int SW_C    = 170,
   parameter int DONE_C  = 341
) (
   input  logic [CODE_W-1:0] ramp_i,
   output logic              below_dis_o,
   output logic              at_sw_o,
   output logic              at_done_o
);
   localparam logic [CODE_W-1:0] DIS_V  = CODE_W'(DIS_C);
   localparam logic [CODE_W-1:0] SW_V   = CODE_W'(SW_C);
   localparam logic [CODE_W-1:0] DONE_V = CODE_W'(DONE_C);

   always_comb begin
      below_dis_o = (ramp_i <  DIS_V);
      at_sw_o     = (ramp_i >= SW_V);
      at_done_o   = (ramp_i >= DONE_V);
   end
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
   import ssp_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       uvlo_i,
   input  logic       en_i,
   input  logic       therm_i,
   input  logic       below_dis_i,
   input  logic       at_sw_i,
   input  logic       at_done_i,
   output ssp_state_e state_o
);
   ssp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (uvlo_i || therm_i || !en_i) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:    state_d = ST_CHARGE;
            ST_CHARGE: if (at_sw_i) state_d = ST_SOFT;
            ST_SOFT: begin
               if (below_dis_i)    state_d = ST_OFF;
               else if (at_done_i) state_d = ST_RUN;
            end
            ST_RUN:    if (below_dis_i) state_d = ST_OFF;
            default:   state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_OFF;
      else         state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/ssp_win_edge.sv
module ssp_win_edge #(
   parameter int CODE_W   = 10,
   parameter int TRIP     = 562,
   parameter int RELEASE  = 556,
   parameter bit UPPER    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] level_i,
   output logic              out_o
);
   localparam logic [CODE_W-1:0] TRIP_V = CODE_W'(TRIP);
   localparam logic [CODE_W-1:0] REL_V  = CODE_W'(RELEASE);

   logic flag_q, set_c, clr_c;

   generate
      if (UPPER) begin : g_upper
         always_comb begin
            set_c = (level_i > TRIP_V);
            clr_c = (level_i < REL_V);
         end
      end else begin : g_lower
         always_comb begin
            set_c = (level_i < TRIP_V);
            clr_c = (level_i > REL_V);
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (set_c) flag_q <= 1'b1;
      else if (clr_c) flag_q <= 1'b0;
   end

   assign out_o = flag_q;
endmodule

// File: rtl/ssp_refgen.sv
module ssp_refgen
   import ssp_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int SW_C   = 170,
   parameter int REF_C  = 85
) (
   input  ssp_state_e        state_i,
   input  logic [CODE_W-1:0] ramp_i,
   output logic [CODE_W-1:0] ref_o
);
   localparam logic [CODE_W:0]   SW_X  = (CODE_W+1)'(SW_C);
   localparam logic [CODE_W-1:0] REF_V = CODE_W'(REF_C);

   logic [CODE_W:0]   diff;
   logic [CODE_W-1:0] track;

   always_comb begin
      diff  = {1'b0, ramp_i} - SW_X;
      track = diff[CODE_W] ? '0 : diff[CODE_W-1:0];
      unique case (state_i)
         ST_OFF:  ref_o = '0;
         ST_RUN:  ref_o = REF_V;
         default: ref_o = (track > REF_V) ? REF_V : track;
      endcase
   end
endmodule

// File: rtl/softstart_pg_seq.sv
module softstart_pg_seq
   import ssp_pkg::*;
#(
   parameter int CODE_W     = 10,
   parameter int RAMP_FS_MV = 6000,
   parameter int FB_FS_MV   = 1000,
   parameter int DIS_MV     = 500,
   parameter int SW_MV      = 1000,
   parameter int DONE_MV    = 2000,
   parameter int REF_MV     = 500,
   parameter int PG_HI_MV   = 550,
   parameter int PG_LO_MV   = 450,
   parameter int PG_HYST_MV = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              uvlo_i,
   input  logic              en_i,
   input  logic              therm_i,
   input  logic [CODE_W-1:0] ramp_code_i,
   input  logic [CODE_W-1:0] fb_code_i,
   output logic              ramp_charge_o,
   output logic              ramp_discharge_o,
   output logic              ramp_hold_hi_o,
   output logic              async_mode_o,
   output logic              switch_en_o,
   output logic              ref_release_o,
   output logic [CODE_W-1:0] ref_code_o,
   output logic              pgood_pull_o
);
   localparam int DIS_CODE  = mv2code(DIS_MV,  RAMP_FS_MV, CODE_W);
   localparam int SW_CODE   = mv2code(SW_MV,   RAMP_FS_MV, CODE_W);
   localparam int DONE_CODE = mv2code(DONE_MV, RAMP_FS_MV, CODE_W);
   localparam int REF_CODE  = mv2code(REF_MV,  RAMP_FS_MV, CODE_W);
   localparam int HI_CODE   = mv2code(PG_HI_MV, FB_FS_MV, CODE_W);
   localparam int LO_CODE   = mv2code(PG_LO_MV, FB_FS_MV, CODE_W);
   localparam int HYS_CODE  = mv2code(PG_HYST_MV, FB_FS_MV, CODE_W);

   // Elaboration-time parameter checks
   if (CODE_W < 4 || CODE_W > 16) begin : g_bad_width
      $error("softstart_pg_seq: CODE_W out of range");
   end
   if (!(DIS_CODE < SW_CODE && SW_CODE < DONE_CODE)) begin : g_bad_order
      $error("softstart_pg_seq: ramp thresholds must ascend");
   end
   if (DONE_CODE >= (1 << CODE_W)) begin : g_bad_done
      $error("softstart_pg_seq: completion threshold beyond full scale");
   end
   if (HYS_CODE < 1 || LO_CODE + HYS_CODE >= HI_CODE - HYS_CODE) begin : g_bad_window
      $error("softstart_pg_seq: power-good window too narrow");
   end

   logic       below_dis, at_sw, at_done;
   logic       ov_flag, uv_flag;
   ssp_state_e state;

   ssp_ramp_cmp #(
      .CODE_W (CODE_W),
      .DIS_C  (DIS_CODE),
      .SW_C   (SW_CODE),
      .DONE_C (DONE_CODE)
   ) u_cmp (
      .ramp_i      (ramp_code_i),
      .below_dis_o (below_dis),
      .at_sw_o     (at_sw),
      .at_done_o   (at_done)
   );

   ssp_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .uvlo_i      (uvlo_i),
      .en_i        (en_i),
      .therm_i     (therm_i),
      .below_dis_i (below_dis),
      .at_sw_i     (at_sw),
      .at_done_i   (at_done),
      .state_o     (state)
   );

   ssp_win_edge #(
      .CODE_W  (CODE_W),
      .TRIP    (HI_CODE),
      .RELEASE (HI_CODE - HYS_CODE),
      .UPPER   (1'b1)
   ) u_over (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (fb_code_i),
      .out_o   (ov_flag)
   );

   ssp_win_edge #(
      .CODE_W  (CODE_W),
      .TRIP    (LO_CODE),
      .RELEASE (LO_CODE + HYS_CODE),
      .UPPER   (1'b0)
   ) u_under (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (fb_code_i),
      .out_o   (uv_flag)
   );

   ssp_refgen #(
      .CODE_W (CODE_W),
      .SW_C   (SW_CODE),
      .REF_C  (REF_CODE)
   ) u_ref (
      .state_i (state),
      .ramp_i  (ramp_code_i),
      .ref_o   (ref_code_o)
   );

   logic drive_run, drive_sync;

   always_comb begin
      ramp_charge_o    = (state == ST_CHARGE) || (state == ST_SOFT);
      ramp_discharge_o = (state == ST_OFF);
      ramp_hold_hi_o   = (state == ST_RUN);
      ref_release_o    = (state == ST_RUN);
      drive_run        = (state == ST_SOFT) || (state == ST_RUN);
      drive_sync       = (state == ST_RUN);
      // Thermal fault removes drive without waiting for a clock edge
      switch_en_o      = drive_run && !therm_i;
      async_mode_o     = !(drive_sync && !therm_i);
      pgood_pull_o     = (state != ST_RUN) || ov_flag || uv_flag;
   end
endmodule

// File: rtl/softstart_pg_seq_chk.sv
module softstart_pg_seq_chk #(
   parameter int CODE_W   = 10,
   parameter int REF_CODE = 85,
   parameter int HI_CODE  = 562,
   parameter int LO_CODE  = 460
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              uvlo_i,
   input logic              en_i,
   input logic              therm_i,
   input logic [CODE_W-1:0] fb_code_i,
   input logic              ramp_charge_o,
   input logic              ramp_discharge_o,
   input logic              ramp_hold_hi_o,
   input logic              async_mode_o,
   input logic              switch_en_o,
   input logic              ref_release_o,
   input logic [CODE_W-1:0] ref_code_o,
   input logic              pgood_pull_o
);
   AST_UVLO_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uvlo_i |=> (ramp_discharge_o && !switch_en_o)); // R1
   AST_EN_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !switch_en_o); // R2
   AST_START_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(switch_en_o) |-> async_mode_o); // R3
   AST_REF_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(ref_code_o) <= REF_CODE); // R4
   AST_SYNC_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !async_mode_o |-> (ref_release_o && ramp_hold_hi_o && switch_en_o)); // R5
   AST_PG_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_release_o |-> pgood_pull_o); // R6
   AST_PG_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(fb_code_i) > HI_CODE) |=> pgood_pull_o); // R7
   AST_PG_UNDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(fb_code_i) < LO_CODE) |=> pgood_pull_o); // R7
   AST_THERM_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      therm_i |-> (!switch_en_o && async_mode_o)); // R9
   AST_RAMP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ramp_charge_o, ramp_discharge_o, ramp_hold_hi_o})); // R10
endmodule

bind softstart_pg_seq softstart_pg_seq_chk #(
   .CODE_W   (CODE_W),
   .REF_CODE (REF_CODE),
   .HI_CODE  (HI_CODE),
   .LO_CODE  (LO_CODE)
) u_chk (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .uvlo_i           (uvlo_i),
   .en_i             (en_i),
   .therm_i          (therm_i),
   .fb_code_i        (fb_code_i),
   .ramp_charge_o    (ramp_charge_o),
   .ramp_discharge_o (ramp_discharge_o),
   .ramp_hold_hi_o   (ramp_hold_hi_o),
   .async_mode_o     (async_mode_o),
   .switch_en_o      (switch_en_o),
   .ref_release_o    (ref_release_o),
   .ref_code_o       (ref_code_o),
   .pgood_pull_o     (pgood_pull_o)
);

// File: tb/softstart_pg_seq_bench.sv
`timescale 1ns/1ps
module softstart_pg_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       uvlo, en, therm;
   logic [9:0] ramp, fb;
   logic       chg, dis, hold, asy, sw, rel, pgl;
   logic [9:0] refc;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   softstart_pg_seq u_softstart_pg_seq (
      .clk_i            (clk),
      .rst_ni           (rst_n),
      .uvlo_i           (uvlo),
      .en_i             (en),
      .therm_i          (therm),
      .ramp_code_i      (ramp),
      .fb_code_i        (fb),
      .ramp_charge_o    (chg),
      .ramp_discharge_o (dis),
      .ramp_hold_hi_o   (hold),
      .async_mode_o     (asy),
      .switch_en_o      (sw),
      .ref_release_o    (rel),
      .ref_code_o       (refc),
      .pgood_pull_o     (pgl)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       uv, en, th;
      logic [9:0] ramp, fb;
      logic       sw, asy, pgl, rel, chg, dis, hold;
      logic [9:0] refc;
   } vec_t;

   localparam int NV = 28;
   //                 req uv en th ramp  fb   sw as pg rl ch ds hd ref
   localparam vec_t VEC [NV] = '{
      '{ 1, 1, 1, 0,    0, 512, 0, 1, 1, 0, 0, 1, 0,  0},  // R1 lockout
      '{10, 0, 1, 0,    0, 512, 0, 1, 1, 0, 1, 0, 0,  0},  // R10 charging
      '{ 2, 0, 1, 0,  100, 512, 0, 1, 1, 0, 1, 0, 0,  0},  // R2 low ramp ignored while charging
      '{ 3, 0, 1, 0,  169, 512, 0, 1, 1, 0, 1, 0, 0,  0},  // R3 just below switching code
      '{ 3, 0, 1, 0,  170, 512, 1, 1, 1, 0, 1, 0, 0,  0},  // R3 high-side only
      '{ 4, 0, 1, 0,  200, 512, 1, 1, 1, 0, 1, 0, 0, 30},  // R4 tracking
      '{ 4, 0, 1, 0,  255, 512, 1, 1, 1, 0, 1, 0, 0, 85},  // R4 at cap
      '{ 4, 0, 1, 0,  300, 512, 1, 1, 1, 0, 1, 0, 0, 85},  // R4 capped
      '{ 6, 0, 1, 0,  340, 512, 1, 1, 1, 0, 1, 0, 0, 85},  // R6 masked
      '{ 5, 0, 1, 0,  341, 512, 1, 0, 0, 1, 0, 0, 1, 85},  // R5 run
      '{ 7, 0, 1, 0, 1023, 562, 1, 0, 0, 1, 0, 0, 1, 85},  // R7 at upper edge
      '{ 7, 0, 1, 0, 1023, 563, 1, 0, 1, 1, 0, 0, 1, 85},  // R7 over
      '{ 8, 0, 1, 0, 1023, 557, 1, 0, 1, 1, 0, 0, 1, 85},  // R8 held
      '{ 8, 0, 1, 0, 1023, 555, 1, 0, 0, 1, 0, 0, 1, 85},  // R8 released
      '{ 7, 0, 1, 0, 1023, 460, 1, 0, 0, 1, 0, 0, 1, 85},  // R7 at lower edge
      '{ 7, 0, 1, 0, 1023, 459, 1, 0, 1, 1, 0, 0, 1, 85},  // R7 under
      '{ 8, 0, 1, 0, 1023, 466, 1, 0, 1, 1, 0, 0, 1, 85},  // R8 held
      '{ 8, 0, 1, 0, 1023, 467, 1, 0, 0, 1, 0, 0, 1, 85},  // R8 released
      '{ 2, 0, 1, 0,   84, 512, 0, 1, 1, 0, 0, 1, 0,  0},  // R2 ramp pulled low in run
      '{10, 0, 1, 0,    0, 512, 0, 1, 1, 0, 1, 0, 0,  0},  // R10 restart charging
      '{ 3, 0, 1, 0,  200, 512, 1, 1, 1, 0, 1, 0, 0, 30},  // R3 switching again
      '{ 2, 0, 1, 0,   84, 512, 0, 1, 1, 0, 0, 1, 0,  0},  // R2 ramp pulled low while switching
      '{ 2, 0, 0, 0,    0, 512, 0, 1, 1, 0, 0, 1, 0,  0},  // R2 disabled
      '{ 2, 0, 0, 0,  500, 512, 0, 1, 1, 0, 0, 1, 0,  0},  // R2 disabled, high ramp
      '{ 4, 0, 1, 0,  400, 512, 0, 1, 1, 0, 1, 0, 0, 85},  // R4 charging, capped
      '{ 3, 0, 1, 0,  400, 512, 1, 1, 1, 0, 1, 0, 0, 85},  // R3 one stage per edge
      '{ 5, 0, 1, 0,  400, 512, 1, 0, 0, 1, 0, 0, 1, 85},  // R5 run
      '{ 2, 0, 0, 0,  400, 512, 0, 1, 1, 0, 0, 1, 0,  0}   // R2 enable dropped in run
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic e_sw, input logic e_asy,
                          input logic e_pgl, input logic e_rel, input logic e_chg,
                          input logic e_dis, input logic e_hold, input int e_ref);
      chk({tag, " switch_en"}, int'(sw), int'(e_sw));
      chk({tag, " async"},     int'(asy), int'(e_asy));
      chk({tag, " pgood_pull"}, int'(pgl), int'(e_pgl));
      chk({tag, " ref_release"}, int'(rel), int'(e_rel));
      chk({tag, " charge"},    int'(chg), int'(e_chg));
      chk({tag, " discharge"}, int'(dis), int'(e_dis));
      chk({tag, " hold_hi"},   int'(hold), int'(e_hold));
      chk({tag, " ref_code"},  int'(refc), e_ref);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; uvlo = 1'b1; en = 1'b0; therm = 1'b0; ramp = '0; fb = 10'd512;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R1 reset", 0, 1, 1, 0, 0, 1, 0, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         uvlo = VEC[i].uv; en = VEC[i].en; therm = VEC[i].th;
         ramp = VEC[i].ramp; fb = VEC[i].fb;
         step();
         chk_all($sformatf("row %0d R%0d", i, VEC[i].req), VEC[i].sw, VEC[i].asy,
                 VEC[i].pgl, VEC[i].rel, VEC[i].chg, VEC[i].dis, VEC[i].hold,
                 int'(VEC[i].refc));
      end

      // R9: thermal fault removes drive at once, shutdown on next edge
      en = 1'b1; ramp = 10'd400; fb = 10'd512;
      step(); step(); step();
      chk("R9 precondition async", int'(asy), 0);
      therm = 1'b1;
      #1;
      chk("R9 immediate switch_en", int'(sw), 0);
      chk("R9 immediate async", int'(asy), 1);
      step();
      chk("R9 shutdown discharge", int'(dis), 1);
      chk("R9 shutdown pgood_pull", int'(pgl), 1);
      therm = 1'b0;
      step(); step(); step();
      chk("R5 rerun hold_hi", int'(hold), 1);

      // R1: lockout from run
      uvlo = 1'b1;
      step();
      chk_all("R1 lockout from run", 0, 1, 1, 0, 0, 1, 0, 0);
      uvlo = 1'b0;
      step(); step(); step();
      chk("R5 run before reset", int'(hold), 1);

      // R10: asynchronous reset from run
      rst_n = 1'b0;
      #1;
      chk_all("R10 async reset", 0, 1, 1, 0, 0, 1, 0, 0);
      step();
      rst_n = 1'b1;

      // R6: good feedback during switching still masked
      fb = 10'd512; ramp = 10'd300;
      step(); step();
      chk("R6 masked while switching", int'(pgl), 1);

      finish_run();
   end
endmodule